// File: doc/BRIEF.md
# Masked Message-Object Acceptance Filter for CAN Reception

This block decides which of a bank of receive/transmit message objects takes a frame that has just arrived from a CAN bus. A pulse on `start` samples the frame's 29-bit identifier, its IDE bit (extended format) and its RTR bit (remote frame). The block then walks the objects one per clock, starting at index 0, and stops at the first object that accepts the frame, so among several accepting objects the lowest index always wins.

Each object brings its own configuration in on flat vectors: a valid bit, a mask-enable bit, an identifier, an identifier mask, an extended flag, an extended-compare flag, a direction bit and a direction-compare flag. A standard 11-bit identifier occupies identifier bits 28 down to 18 of both the frame and the object. When the scan ends, `done` pulses for one cycle and `hit` and `hitIdx` give the outcome; both hold until the next search completes. The object store and the writing of object contents live outside this block; the configuration inputs must stay stable while a search runs.

Top module: `can_acc_filter`

## Requirements
- R1: An object whose valid bit is 0 never accepts a frame, whatever its other fields hold.
- R2: With mask-enable at 0 the mask and both compare flags are ignored; the object accepts only if its extended flag equals the frame's IDE bit, its direction bit equals the frame's RTR bit, and every compared identifier bit matches.
- R3: With mask-enable at 1, an identifier mask bit of 0 makes that identifier bit a don't-care and a mask bit of 1 requires the frame bit to equal the object bit.
- R4: When the frame's IDE bit is 0 only identifier bits 28 to 18 are compared (masked by mask bits 28 to 18); bits 17 to 0 of the frame and the object have no effect.
- R5: With mask-enable at 1 and the extended-compare flag at 1 the object's extended flag must equal the frame's IDE bit; with the flag at 0 the object's extended flag is ignored and the frame's IDE bit alone picks the 11-bit or 29-bit comparison.
- R6: With mask-enable at 1 and the direction-compare flag at 1, a direction bit of 0 (receive) accepts only data frames (RTR 0) and a direction bit of 1 (transmit) accepts only remote frames (RTR 1); with the flag at 0 the frame type is ignored.
- R7: When several objects accept, `hitIdx` is the lowest index among them.
- R8: With `start` sampled at rising edge S, `done` is high for exactly one cycle after edge S+k+1 when object k wins, and after edge S+NUM_OBJ when no object accepts.
- R9: When no object accepts, `hit` is 0 and `hitIdx` is 0; `hit` and `hitIdx` hold their values between completed searches.
- R10: A `start` pulse during a running search is ignored, and the frame fields are sampled only at an accepted `start`.
- R11: After reset `done`, `hit` and `hitIdx` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a search with the frame fields present this cycle |
| frmId | input | 29 | Received identifier; standard IDs in bits 28..18 |
| frmIde | input | 1 | Frame uses the 29-bit identifier format |
| frmRtr | input | 1 | Frame is a remote frame |
| objValid | input | NUM_OBJ | Per-object valid bit |
| objUMask | input | NUM_OBJ | Per-object mask-enable bit |
| objId | input | NUM_OBJ*29 | Object identifiers, object i at bits [29*i +: 29] |
| objMask | input | NUM_OBJ*29 | Object identifier masks, same packing |
| objXtd | input | NUM_OBJ | Per-object extended flag |
| objMXtd | input | NUM_OBJ | Per-object extended-compare flag |
| objDir | input | NUM_OBJ | Per-object direction, 1 = transmit |
| objMDir | input | NUM_OBJ | Per-object direction-compare flag |
| done | output | 1 | One-cycle pulse when a search ends |
| hit | output | 1 | Last search found an accepting object |
| hitIdx | output | $clog2(NUM_OBJ) | Index of the winning object, 0 on a miss |

## Verification
The bound checker watches, on every cycle, that `done` is a single-cycle pulse ending a scan, that a reported winner is a valid object, that a miss reports index 0, that an idle `start` always launches a scan and that the result stays put between searches. Whether the right object wins, which needs the identifier, mask, format and direction rules and the lowest-index priority, and the exact cycle of `done` for a given winner, can only be shown by the bench's scenarios with known configurations. The bench also shows that a second `start` mid-search changes neither the result nor the number of `done` pulses.

// File: rtl/can_acc_pkg.sv
package can_acc_pkg;
  localparam int ID_W  = 29;
  localparam int STD_W = 11;

  // strobes from the scan control to the datapath
  typedef struct packed {
    logic capture;  // latch the frame fields
    logic record;   // store the outcome of the current compare
  } acc_strobe_t;
endpackage

// File: rtl/can_acc_ctrl.sv
module can_acc_ctrl
  import can_acc_pkg::*;
#(
  parameter int NUM_OBJ = 32,
  localparam int IDX_W = $clog2(NUM_OBJ)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             curMatch,
  output acc_strobe_t      strobe,
  output logic [IDX_W-1:0] scanIdx,
  output logic             busy,
  output logic             done
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_OBJ - 1);

  typedef enum logic {S_IDLE, S_SCAN} scan_state_t;
  scan_state_t state;

  assign busy = (state == S_SCAN);

  always_comb begin
    strobe.capture = (state == S_IDLE) && start;
    strobe.record  = (state == S_SCAN) && (curMatch || scanIdx == LAST_IDX);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      scanIdx <= '0;
      done    <= 1'b0;
    end else begin
      done <= strobe.record;
      if (strobe.capture) begin
        state   <= S_SCAN;
        scanIdx <= '0;
      end else if (strobe.record) begin
        state <= S_IDLE;
      end else if (state == S_SCAN) begin
        scanIdx <= scanIdx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/can_acc_dpath.sv
module can_acc_dpath
  import can_acc_pkg::*;
#(
  parameter int NUM_OBJ = 32,
  localparam int IDX_W = $clog2(NUM_OBJ)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  acc_strobe_t             strobe,
  input  logic [IDX_W-1:0]        scanIdx,
  input  logic [ID_W-1:0]         frmId,
  input  logic                    frmIde,
  input  logic                    frmRtr,
  input  logic [NUM_OBJ-1:0]      objValid,
  input  logic [NUM_OBJ-1:0]      objUMask,
  input  logic [NUM_OBJ*ID_W-1:0] objId,
  input  logic [NUM_OBJ*ID_W-1:0] objMask,
  input  logic [NUM_OBJ-1:0]      objXtd,
  input  logic [NUM_OBJ-1:0]      objMXtd,
  input  logic [NUM_OBJ-1:0]      objDir,
  input  logic [NUM_OBJ-1:0]      objMDir,
  output logic                    curMatch,
  output logic                    hit,
  output logic [IDX_W-1:0]        hitIdx
);
  localparam logic [ID_W-1:0] STD_REGION = {{STD_W{1'b1}}, {(ID_W-STD_W){1'b0}}};

  logic [ID_W-1:0] idQ;
  logic            ideQ, rtrQ;

  logic [ID_W-1:0] selId, selMask, region, cmpMask;
  logic            selValid, selUMask, selXtd, selMXtd, selDir, selMDir;
  logic            idOk, xtdOk, dirOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idQ  <= '0;
      ideQ <= 1'b0;
      rtrQ <= 1'b0;
    end else if (strobe.capture) begin
      idQ  <= frmId;
      ideQ <= frmIde;
      rtrQ <= frmRtr;
    end
  end

  always_comb begin
    selId    = objId[scanIdx*ID_W +: ID_W];
    selMask  = objMask[scanIdx*ID_W +: ID_W];
    selValid = objValid[scanIdx];
    selUMask = objUMask[scanIdx];
    selXtd   = objXtd[scanIdx];
    selMXtd  = objMXtd[scanIdx];
    selDir   = objDir[scanIdx];
    selMDir  = objMDir[scanIdx];

    region  = ideQ ? '1 : STD_REGION;
    cmpMask = selUMask ? selMask : '1;
    idOk    = (((selId ^ idQ) & cmpMask & region) == '0);
    xtdOk   = (!selUMask || selMXtd) ? (selXtd == ideQ) : 1'b1;
    dirOk   = (!selUMask || selMDir) ? (selDir == rtrQ) : 1'b1;
    curMatch = selValid && idOk && xtdOk && dirOk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hit    <= 1'b0;
      hitIdx <= '0;
    end else if (strobe.record) begin
      hit    <= curMatch;
      hitIdx <= curMatch ? scanIdx : '0;
    end
  end
endmodule

// File: rtl/can_acc_filter.sv
module can_acc_filter
  import can_acc_pkg::*;
#(
  parameter int NUM_OBJ = 32,
  localparam int IDX_W = $clog2(NUM_OBJ)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic [ID_W-1:0]         frmId,
  input  logic                    frmIde,
  input  logic                    frmRtr,
  input  logic [NUM_OBJ-1:0]      objValid,
  input  logic [NUM_OBJ-1:0]      objUMask,
  input  logic [NUM_OBJ*ID_W-1:0] objId,
  input  logic [NUM_OBJ*ID_W-1:0] objMask,
  input  logic [NUM_OBJ-1:0]      objXtd,
  input  logic [NUM_OBJ-1:0]      objMXtd,
  input  logic [NUM_OBJ-1:0]      objDir,
  input  logic [NUM_OBJ-1:0]      objMDir,
  output logic                    done,
  output logic                    hit,
  output logic [IDX_W-1:0]        hitIdx
);
  acc_strobe_t      strobe;
  logic [IDX_W-1:0] scanIdx;
  logic             curMatch;
  logic             busy;

  can_acc_ctrl #(.NUM_OBJ(NUM_OBJ)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .curMatch(curMatch),
    .strobe(strobe), .scanIdx(scanIdx), .busy(busy), .done(done)
  );

  can_acc_dpath #(.NUM_OBJ(NUM_OBJ)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .scanIdx(scanIdx),
    .frmId(frmId), .frmIde(frmIde), .frmRtr(frmRtr),
    .objValid(objValid), .objUMask(objUMask), .objId(objId), .objMask(objMask),
    .objXtd(objXtd), .objMXtd(objMXtd), .objDir(objDir), .objMDir(objMDir),
    .curMatch(curMatch), .hit(hit), .hitIdx(hitIdx)
  );
endmodule

// File: rtl/can_acc_checker.sv
module can_acc_checker #(
  parameter int NUM_OBJ = 32,
  localparam int IDX_W = $clog2(NUM_OBJ)
) (
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic               busy,
  input logic               done,
  input logic               hit,
  input logic [IDX_W-1:0]   hitIdx,
  input logic [NUM_OBJ-1:0] objValid
);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_ends_scan_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(busy));

  p_winner_valid_r1: assert property (@(posedge clk) disable iff (!rstN)
    (done && hit) |-> objValid[hitIdx]);

  p_miss_index_r9: assert property (@(posedge clk) disable iff (!rstN)
    (done && !hit) |-> (hitIdx == '0));

  p_result_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!done && !busy) |-> ($stable(hit) && $stable(hitIdx)));

  p_start_launch_r10: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);
endmodule

bind can_acc_filter can_acc_checker #(.NUM_OBJ(NUM_OBJ)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .hit(hit), .hitIdx(hitIdx), .objValid(objValid)
);

// File: tb/test_can_acc_filter.sv
module test_can_acc_filter;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;
  localparam int IW = 29;
  localparam int XW = $clog2(N);
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [IW-1:0] frmId = '0;
  logic frmIde = 1'b0, frmRtr = 1'b0;
  logic [N-1:0] objValid = '0, objUMask = '0, objXtd = '0, objMXtd = '0, objDir = '0, objMDir = '0;
  logic [N*IW-1:0] objId = '0, objMask = '0;
  logic done, hit;
  logic [XW-1:0] hitIdx;

  int cyc = 0;
  int checks = 0;
  int errors = 0;

  typedef struct {
    logic hit;
    int   idx;
    int   doneCyc;
    string tag;
  } exp_t;
  exp_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  can_acc_filter #(.NUM_OBJ(N)) i_can_acc_filter (
    .clk(clk), .rstN(rstN), .start(start), .frmId(frmId), .frmIde(frmIde), .frmRtr(frmRtr),
    .objValid(objValid), .objUMask(objUMask), .objId(objId), .objMask(objMask),
    .objXtd(objXtd), .objMXtd(objMXtd), .objDir(objDir), .objMDir(objMDir),
    .done(done), .hit(hit), .hitIdx(hitIdx)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WATCHDOG) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual cycle %0d expected below %0d", cyc, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int expv);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", what, act, expv);
    end
  endtask

  // monitor: pops expectations as done pulses arrive
  always @(negedge clk) begin
    if (rstN && done) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R10 unexpected done pulse", 1, 0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        check(hit == e.hit, {e.tag, " hit"}, int'(hit), int'(e.hit));
        check(int'(hitIdx) == e.idx, {e.tag, " index"}, int'(hitIdx), e.idx);
        check(cyc == e.doneCyc, {e.tag, " R8 done timing"}, cyc, e.doneCyc);
      end
    end
  end

  task automatic clearObjs();
    objValid = '0; objUMask = '0; objXtd = '0; objMXtd = '0; objDir = '0; objMDir = '0;
    objId = '0; objMask = '0;
  endtask

  task automatic setObj(input int i, input logic [IW-1:0] id, input logic [IW-1:0] msk,
                        input logic um, input logic xtd, input logic mxtd,
                        input logic dir, input logic mdir);
    objValid[i] = 1'b1;
    objUMask[i] = um;
    objId[i*IW +: IW] = id;
    objMask[i*IW +: IW] = msk;
    objXtd[i] = xtd; objMXtd[i] = mxtd;
    objDir[i] = dir; objMDir[i] = mdir;
  endtask

  // driver: launch at a falling edge, start is sampled at the next rising edge
  task automatic launch(input logic [IW-1:0] id, input logic ide, input logic rtr,
                        input logic expHit, input int expIdx, input string tag);
    exp_t e;
    e.hit = expHit;
    e.idx = expHit ? expIdx : 0;
    e.doneCyc = cyc + 1 + (expHit ? expIdx + 1 : N);
    e.tag = tag;
    expQ.push_back(e);
    frmId = id; frmIde = ide; frmRtr = rtr; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone();
    while (expQ.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic search(input logic [IW-1:0] id, input logic ide, input logic rtr,
                        input logic expHit, input int expIdx, input string tag);
    launch(id, ide, rtr, expHit, expIdx, tag);
    waitDone();
    // R9: result holds after the search
    repeat (2) @(negedge clk);
    check(hit == expHit, {tag, " R9 hit held"}, int'(hit), int'(expHit));
  endtask

  localparam logic [IW-1:0] ONES = '1;
  localparam logic [IW-1:0] EXT_A = 29'h1ABC_DEF0;

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check(done == 1'b0, "R11 done after reset", int'(done), 0);
    check(hit == 1'b0, "R11 hit after reset", int'(hit), 0);
    check(hitIdx == '0, "R11 index after reset", int'(hitIdx), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1/R9: nothing valid, miss after full scan
    clearObjs();
    search(EXT_A, 1'b1, 1'b0, 1'b0, 0, "R1 R9 all invalid");

    // R2: mask disabled, exact compare
    clearObjs();
    setObj(5, EXT_A, '0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    search(EXT_A, 1'b1, 1'b0, 1'b1, 5, "R2 exact hit");
    search(EXT_A ^ 29'h1, 1'b1, 1'b0, 1'b0, 0, "R2 id bit 0 differs");
    search(EXT_A, 1'b1, 1'b1, 1'b0, 0, "R2 remote vs receive object");
    search(EXT_A, 1'b0, 1'b0, 1'b0, 0, "R2 format differs");
    objValid[5] = 1'b0;
    search(EXT_A, 1'b1, 1'b0, 1'b0, 0, "R1 object invalidated");

    // R3: masked low byte is don't-care, bit 8 is compared
    clearObjs();
    setObj(3, EXT_A, 29'h1FFF_FF00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
    search(EXT_A ^ 29'hA5, 1'b1, 1'b0, 1'b1, 3, "R3 masked bits differ");
    search(EXT_A ^ 29'h100, 1'b1, 1'b0, 1'b0, 0, "R3 unmasked bit differs");

    // R4: standard frame, low 18 bits ignored on both sides
    clearObjs();
    setObj(7, {11'h123, 18'h15555}, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    search({11'h123, 18'h3FFFF}, 1'b0, 1'b0, 1'b1, 7, "R4 std low bits ignored");
    search({11'h122, 18'h15555}, 1'b0, 1'b0, 1'b0, 0, "R4 std bit 18 differs");

    // R5: extended-compare flag
    clearObjs();
    setObj(9, {11'h5A5, 18'h0}, ONES, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    search({11'h5A5, 18'h0}, 1'b1, 1'b0, 1'b1, 9, "R5 flag 0 ignores format");
    search({11'h5A5, 18'h1}, 1'b1, 1'b0, 1'b0, 0, "R5 ide picks 29-bit compare");
    objMXtd[9] = 1'b1;
    search({11'h5A5, 18'h0}, 1'b1, 1'b0, 1'b0, 0, "R5 flag 1 format mismatch");
    search({11'h5A5, 18'h0}, 1'b0, 1'b0, 1'b1, 9, "R5 flag 1 format match");

    // R6: direction-compare flag
    clearObjs();
    setObj(11, EXT_A, ONES, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    search(EXT_A, 1'b1, 1'b1, 1'b1, 11, "R6 flag 0 ignores type");
    objMDir[11] = 1'b1; objDir[11] = 1'b1;
    search(EXT_A, 1'b1, 1'b1, 1'b1, 11, "R6 transmit obj remote frame");
    search(EXT_A, 1'b1, 1'b0, 1'b0, 0, "R6 transmit obj data frame");

    // R7: lowest index wins
    clearObjs();
    setObj(4, EXT_A, 29'h1FFF_0000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
    setObj(20, EXT_A, '0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    search(EXT_A, 1'b1, 1'b0, 1'b1, 4, "R7 two matches");
    objValid[4] = 1'b0;
    search(EXT_A, 1'b1, 1'b0, 1'b1, 20, "R7 upper match only");
    clearObjs();
    setObj(N-1, EXT_A, '0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    search(EXT_A, 1'b1, 1'b0, 1'b1, N-1, "R7 R8 last object");

    // R10: second start mid-search is ignored
    clearObjs();
    setObj(10, EXT_A, '0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    setObj(0, 29'h0000_1234, '0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    launch(EXT_A, 1'b1, 1'b0, 1'b1, 10, "R10 first start wins");
    repeat (3) @(negedge clk);
    frmId = 29'h0000_1234; frmIde = 1'b1; frmRtr = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitDone();
    repeat (15) @(negedge clk);
    check(hitIdx == XW'(10), "R10 result after ignored start", int'(hitIdx), 10);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule